// File: doc/BRIEF.md
# Hashed Page Table Walker

This engine resolves a translation miss by searching a hashed page table held in memory. It takes a virtual page number and hashes it to pick a slot. The slot's word address is the table base plus the slot number times the slot size. The engine then fetches the slot's eight entries one after another over a single-outstanding read port and compares each stored tag with the requested page number. The first valid entry whose tag matches ends the walk with its physical page number.

When all eight entries of the first slot miss, a second hash picks an alternate slot, which is searched in the same way. If that slot also misses, the walk ends with a fault flag, and software then searches the full page table. The requester sees the walk input as a valid/ready channel: a request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the engine is idle, so a requester facing back-pressure holds `req_vpn` until it is accepted. The read port is also valid/ready. Once `mem_req_valid` rises, it and `mem_req_addr` stay unchanged until `mem_req_ready` is seen high. The response comes back any number of cycles later as a one-cycle `mem_rsp_valid`. The result is reported on plain pins as a one-cycle pulse.

Top module: `hpt_walker`

## Requirements
- R1: A walk is accepted only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only while no walk is in progress, and a `req_valid` raised during a walk starts nothing and produces no extra read or result.
- R2: The primary slot number is H1 = (vpn[15:8] XOR vpn[7:0]) AND (SLOTS-1), with SLOTS = 16 by default. The i-th entry of that slot is read from word address `table_base + H1*8 + i`.
- R3: Entries of a slot are read in order i = 0..7, with at most one read outstanding at any time. A new read is issued only after the response to the previous one has arrived.
- R4: An entry word is {valid at bit 28, tag at bits 27:12, ppn at bits 11:0}. An entry matches only when its valid bit is 1 and its tag equals the requested page number; a tag-equal entry with valid 0 is skipped.
- R5: The walk stops at the first matching entry. A match at position k of the primary slot costs exactly k+1 reads, and a later entry with the same tag is never read.
- R6: If no primary entry matches, the alternate slot H2 = (NOT H1) AND (SLOTS-1) is searched at `table_base + H2*8 + i`, for i = 0..7. A match at position k there costs 8+k+1 reads.
- R7: If neither slot matches, the walk ends after exactly 16 reads with `fault` = 1 and `hit` = 0.
- R8: `done` is high for exactly one cycle per accepted walk. On that cycle exactly one of `hit` and `fault` is high, and on a hit `ppn` carries the matching entry's ppn field.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged on the next cycle.
- R10: After reset, `req_ready` = 1, and `done`, `hit`, `fault` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| table_base | input | ADDR_W | Word address of slot 0 |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_vpn | input | VPN_W | Virtual page number to translate |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | ADDR_W | Word address of the entry |
| mem_rsp_valid | input | 1 | Read data present (one cycle) |
| mem_rsp_data | input | VPN_W+PPN_W+1 | Entry word {valid, tag, ppn} |
| done | output | 1 | One-cycle walk completion |
| hit | output | 1 | Translation found (with done) |
| fault | output | 1 | No translation in either slot (with done) |
| ppn | output | PPN_W | Physical page number on a hit |

## Verification
The bench is driven through a memory model whose ready line and response latency vary pseudo-randomly. One sweep places a single match at each of the eight primary positions for many page numbers, which exposes a wrong hash, a wrong base addition or a wrong read count. A second sweep fills the primary slot with valid entries that carry other tags and puts the match at each alternate position, which exposes a missing or mis-hashed secondary search. Further walks check the full-miss fault, a tag-equal entry with its valid bit clear, two matching entries in one slot (the earlier must win), a moved table base, and requests raised while a walk is in progress. Each walk's expected result, read count and full address sequence are computed arithmetically from the page number and the memory contents.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int VPN_W     = 16,
  parameter int SLOT_BITS = 4
) (
  input  logic [VPN_W-1:0]     vpn,
  output logic [SLOT_BITS-1:0] slot_pri,
  output logic [SLOT_BITS-1:0] slot_alt
);
  localparam int LO_W = VPN_W / 2;
  localparam int HI_W = VPN_W - LO_W;

  logic [HI_W-1:0] folded;

  always_comb begin
    folded   = vpn[VPN_W-1:LO_W] ^ HI_W'(vpn[LO_W-1:0]);
    slot_pri = folded[SLOT_BITS-1:0];
    slot_alt = ~folded[SLOT_BITS-1:0];
  end
endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen #(
  parameter int ADDR_W    = 24,
  parameter int SLOT_BITS = 4,
  parameter int WAY_BITS  = 3
) (
  input  logic [ADDR_W-1:0]    base,
  input  logic [SLOT_BITS-1:0] slot,
  input  logic [WAY_BITS-1:0]  way,
  output logic [ADDR_W-1:0]    addr
);
  localparam int OFF_W = SLOT_BITS + WAY_BITS;

  logic [OFF_W-1:0] offset;

  always_comb begin
    offset = {slot, way};
    addr   = base + ADDR_W'(offset);
  end
endmodule

// File: rtl/hpt_entry_cmp.sv
module hpt_entry_cmp #(
  parameter int VPN_W = 16,
  parameter int PPN_W = 12
) (
  input  logic [VPN_W+PPN_W:0] entry,
  input  logic [VPN_W-1:0]     vpn,
  output logic                 match,
  output logic [PPN_W-1:0]     entry_ppn
);
  localparam int VLD_BIT = VPN_W + PPN_W;

  logic             ent_vld;
  logic [VPN_W-1:0] ent_tag;

  always_comb begin
    ent_vld   = entry[VLD_BIT];
    ent_tag   = entry[VLD_BIT-1:PPN_W];
    entry_ppn = entry[PPN_W-1:0];
    match     = ent_vld && (ent_tag == vpn);
  end
endmodule

// File: rtl/hpt_walk_ctrl.sv
module hpt_walk_ctrl
  import hpt_pkg::*;
#(
  parameter int VPN_W    = 16,
  parameter int PPN_W    = 12,
  parameter int WAY_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VPN_W-1:0]    req_vpn,
  output logic [VPN_W-1:0]    vpn_q,
  output logic                use_alt,
  output logic [WAY_BITS-1:0] way_idx,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  input  logic                mem_rsp_valid,
  input  logic                entry_match,
  input  logic [PPN_W-1:0]    entry_ppn,
  output logic                done,
  output logic                hit,
  output logic                fault,
  output logic [PPN_W-1:0]    ppn
);
  localparam logic [WAY_BITS-1:0] LAST_WAY = '1;

  walk_st_e            st;
  logic                alt_q;
  logic                hit_q;
  logic [WAY_BITS-1:0] idx_q;
  logic [PPN_W-1:0]    ppn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      vpn_q <= '0;
      alt_q <= 1'b0;
      idx_q <= '0;
      hit_q <= 1'b0;
      ppn_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q <= req_vpn;
            alt_q <= 1'b0;
            idx_q <= '0;
            hit_q <= 1'b0;
            st    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (entry_match) begin
              hit_q <= 1'b1;
              ppn_q <= entry_ppn;
              st    <= ST_DONE;
            end else if (idx_q == LAST_WAY) begin
              if (alt_q) begin
                st <= ST_DONE;
              end else begin
                alt_q <= 1'b1;
                idx_q <= '0;
                st    <= ST_ISSUE;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
              st    <= ST_ISSUE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (st == ST_IDLE);
    mem_req_valid = (st == ST_ISSUE);
    done          = (st == ST_DONE);
    hit           = done && hit_q;
    fault         = done && !hit_q;
    ppn           = hit ? ppn_q : '0;
    use_alt       = alt_q;
    way_idx       = idx_q;
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int VPN_W     = 16,
  parameter int PPN_W     = 12,
  parameter int ADDR_W    = 24,
  parameter int SLOT_BITS = 4,
  parameter int WAY_BITS  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      table_base,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VPN_W-1:0]       req_vpn,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [ADDR_W-1:0]      mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [VPN_W+PPN_W:0]   mem_rsp_data,
  output logic                   done,
  output logic                   hit,
  output logic                   fault,
  output logic [PPN_W-1:0]       ppn
);
  logic [VPN_W-1:0]     vpn_q;
  logic                 use_alt;
  logic [WAY_BITS-1:0]  way_idx;
  logic [SLOT_BITS-1:0] slot_pri;
  logic [SLOT_BITS-1:0] slot_alt;
  logic [SLOT_BITS-1:0] slot_sel;
  logic                 entry_match;
  logic [PPN_W-1:0]     entry_ppn;

  hpt_hash #(.VPN_W(VPN_W), .SLOT_BITS(SLOT_BITS)) u_hash (
    .vpn      (vpn_q),
    .slot_pri (slot_pri),
    .slot_alt (slot_alt)
  );

  assign slot_sel = use_alt ? slot_alt : slot_pri;

  hpt_addr_gen #(.ADDR_W(ADDR_W), .SLOT_BITS(SLOT_BITS), .WAY_BITS(WAY_BITS)) u_addr (
    .base (table_base),
    .slot (slot_sel),
    .way  (way_idx),
    .addr (mem_req_addr)
  );

  hpt_entry_cmp #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_cmp (
    .entry     (mem_rsp_data),
    .vpn       (vpn_q),
    .match     (entry_match),
    .entry_ppn (entry_ppn)
  );

  hpt_walk_ctrl #(.VPN_W(VPN_W), .PPN_W(PPN_W), .WAY_BITS(WAY_BITS)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vpn       (req_vpn),
    .vpn_q         (vpn_q),
    .use_alt       (use_alt),
    .way_idx       (way_idx),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .entry_match   (entry_match),
    .entry_ppn     (entry_ppn),
    .done          (done),
    .hit           (hit),
    .fault         (fault),
    .ppn           (ppn)
  );
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              done,
  input logic              hit,
  input logic              fault
);
  logic in_flight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_flight <= 1'b0;
    else if (mem_req_valid && mem_req_ready) in_flight <= 1'b1;
    else if (mem_rsp_valid) in_flight <= 1'b0;
  end

  assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !in_flight);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hit != fault));

  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || done) |-> !req_ready);
endmodule

bind hpt_walker hpt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done),
  .hit           (hit),
  .fault         (fault)
);

// File: tb/tb_hpt_walker.sv
module tb_hpt_walker;
  localparam int VPN_W = 16;
  localparam int PPN_W = 12;
  localparam int ADDR_W = 24;
  localparam int SLOTS = 16;
  localparam int WAYS = 8;
  localparam int DEPTH = SLOTS * WAYS;
  localparam int EW = VPN_W + PPN_W + 1;

  logic clk, rst_n;
  logic [ADDR_W-1:0] table_base;
  logic req_valid, req_ready;
  logic [VPN_W-1:0] req_vpn;
  logic mem_req_valid, mem_req_ready;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [EW-1:0] mem_rsp_data;
  logic done, hit, fault;
  logic [PPN_W-1:0] ppn;

  hpt_walker dut (
    .clk(clk), .rst_n(rst_n), .table_base(table_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .hit(hit), .fault(fault), .ppn(ppn)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;

  logic [EW-1:0]     mem [0:DEPTH-1];
  logic [ADDR_W-1:0] addr_log [0:31];
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        lf;
  logic [1:0]        cnt;
  logic              pending, overlap;
  int                rd_count;

  function automatic logic [EW-1:0] lookup(input logic [ADDR_W-1:0] a);
    int off;
    off = int'(a) - int'(table_base);
    if (off >= 0 && off < DEPTH) return mem[off];
    return '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0; cnt <= '0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
      mem_req_ready <= 1'b0; lf <= 8'h5a; rd_count <= 0; overlap <= 1'b0; rd_addr <= '0;
    end else begin
      lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mem_req_ready <= lf[0] | lf[3];
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (pending) overlap <= 1'b1;
        pending <= 1'b1;
        cnt <= lf[2:1];
        rd_addr <= mem_req_addr;
        addr_log[rd_count % 32] <= mem_req_addr;
        rd_count <= rd_count + 1;
      end else if (pending) begin
        if (cnt == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data <= lookup(rd_addr);
          pending <= 1'b0;
        end else cnt <= cnt - 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int h1_of(input int v);
    return (((v >> 8) ^ (v & 255)) & (SLOTS - 1));
  endfunction

  function automatic int slot_of(input int v, input int alt);
    return alt ? ((~h1_of(v)) & (SLOTS - 1)) : h1_of(v);
  endfunction

  function automatic logic [EW-1:0] mk(input bit v, input int tag, input int p);
    return {v, tag[VPN_W-1:0], p[PPN_W-1:0]};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  task automatic put(input int slot, input int way, input logic [EW-1:0] e);
    mem[slot * WAYS + way] = e;
  endtask

  task automatic ref_search(input int v, output bit eh, output int ep, output int er);
    eh = 0; ep = 0; er = 0;
    for (int alt = 0; alt < 2 && !eh; alt++) begin
      for (int k = 0; k < WAYS && !eh; k++) begin
        logic [EW-1:0] e;
        e = mem[slot_of(v, alt) * WAYS + k];
        er++;
        if (e[EW-1] && int'(e[EW-2:PPN_W]) == v) begin
          eh = 1; ep = int'(e[PPN_W-1:0]);
        end
      end
    end
  endtask

  task automatic run_walk(input int v, input string tag);
    bit eh; int ep, er, start, n, reads;
    bit seq_ok;
    logic [ADDR_W-1:0] bad_a, bad_e;
    bit got_hit, got_fault;
    logic [PPN_W-1:0] got_ppn;
    ref_search(v, eh, ep, er);
    @(negedge clk);
    req_vpn = v[VPN_W-1:0];
    req_valid = 1'b1;
    start = rd_count;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    got_hit = hit; got_fault = fault; got_ppn = ppn;
    reads = rd_count - start;
    check(done == 1'b1, {tag, " R8 done seen"}, done, 1);
    check(got_hit == eh, {tag, " R5/R6 hit"}, got_hit, eh);
    check(got_fault == !eh, {tag, " R7 fault"}, got_fault, !eh);
    if (eh) check(got_ppn == ep[PPN_W-1:0], {tag, " R4 ppn"}, got_ppn, ep);
    check(reads == er, {tag, " R5 read count"}, reads, er);
    seq_ok = 1; bad_a = '0; bad_e = '0;
    for (int i = 0; i < er && i < 16; i++) begin
      logic [ADDR_W-1:0] ea;
      ea = table_base + ADDR_W'(slot_of(v, i / WAYS) * WAYS + (i % WAYS));
      if (addr_log[(start + i) % 32] !== ea && seq_ok) begin
        seq_ok = 0; bad_a = addr_log[(start + i) % 32]; bad_e = ea;
      end
    end
    check(seq_ok, {tag, " R2/R3/R9 address order"}, bad_a, bad_e);
    @(negedge clk);
    check(done == 1'b0, {tag, " R8 single pulse"}, done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vpn = '0; table_base = 24'h000100;
    clear_mem();
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
    check(done == 1'b0 && hit == 1'b0 && fault == 1'b0, "R10 outputs idle", {done, hit, fault}, 0);
    check(mem_req_valid == 1'b0, "R10 no read", mem_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R4 R5: primary hit at every position, many page numbers
    for (int i = 0; i < 32; i++) begin
      int v, s;
      v = (i * 40503 + 7) & 16'hffff;
      s = slot_of(v, 0);
      clear_mem();
      for (int j = 0; j < WAYS; j++) put(s, j, mk(1, v ^ (j + 1) * 256, j));
      put(s, i % WAYS, mk(1, v, (i * 37 + 1) & 12'hfff));
      run_walk(v, "primary sweep");
    end

    // R6: alternate slot hit at every position
    for (int k = 0; k < WAYS; k++) begin
      int v;
      v = 16'h3c00 + k * 97;
      clear_mem();
      for (int j = 0; j < WAYS; j++) put(slot_of(v, 0), j, mk(1, v ^ 16'h0100, j + 5));
      put(slot_of(v, 1), k, mk(1, v, 12'h800 + k));
      run_walk(v, "alternate sweep");
    end

    // R7: full miss, empty and then with other tags present
    clear_mem();
    run_walk(16'h1234, "miss empty");
    for (int j = 0; j < WAYS; j++) begin
      put(slot_of(16'h1234, 0), j, mk(1, 16'h1235 + j, 1));
      put(slot_of(16'h1234, 1), j, mk(0, 16'h1234, 2));
    end
    run_walk(16'h1234, "miss populated R4");

    // R4: tag-equal entry with valid clear is skipped
    clear_mem();
    put(slot_of(16'hbeef, 0), 2, mk(0, 16'hbeef, 12'h111));
    put(slot_of(16'hbeef, 0), 5, mk(1, 16'hbeef, 12'h555));
    run_walk(16'hbeef, "invalid skip R4");

    // R5: two matches in one slot, earlier wins
    clear_mem();
    put(slot_of(16'h0f0f, 0), 1, mk(1, 16'h0f0f, 12'h0a1));
    put(slot_of(16'h0f0f, 0), 4, mk(1, 16'h0f0f, 12'h0b4));
    run_walk(16'h0f0f, "first match R5");

    // R2: moved table base
    table_base = 24'h040000;
    clear_mem();
    put(slot_of(16'h7a31, 0), 6, mk(1, 16'h7a31, 12'hc06));
    run_walk(16'h7a31, "new base R2");

    // R1: requests during a walk are ignored
    begin
      int start, n;
      bit ready_seen;
      clear_mem();
      @(negedge clk);
      req_vpn = 16'h4444; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      start = rd_count;
      put(slot_of(16'h5555, 0), 0, mk(1, 16'h5555, 12'h055));
      req_vpn = 16'h5555;
      ready_seen = 0;
      for (int c = 0; c < 6; c++) begin
        if (req_ready) ready_seen = 1;
        @(negedge clk);
      end
      req_valid = 1'b0;
      check(!ready_seen, "R1 ready low while busy", ready_seen, 0);
      n = 0;
      while (!done && n < 400) begin @(negedge clk); n++; end
      check(fault == 1'b1, "R1 first walk result kept", fault, 1);
      @(negedge clk);
      n = 0;
      for (int c = 0; c < 30; c++) begin
        if (done) n++;
        @(negedge clk);
      end
      check(n == 0, "R1 no second result", n, 0);
      check(rd_count - start <= 16, "R1 no extra reads", rd_count - start, 16);
    end

    check(!overlap, "R3 one read outstanding", overlap, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule